// File: doc/BRIEF.md
# Static Memory Burst Read Controller

This block runs burst reads on an external asynchronous static memory or expansion bus. An on-chip requester supplies a start address, a transfer size (byte, halfword or word) and a beat count. The block then asserts the active-low select and read strobes. It steps the address by the transfer size from beat to beat and returns one captured data word per beat, each with a one-cycle valid pulse.

Each beat lasts a whole number of clocks. The first beat of a burst always carries at least one wait state, so a burst at its fastest follows a 1-0-0-0 pattern. Programmed wait counts lengthen the beats. An external ready line, sampled on the falling clock edge inside the final clock of a beat, can hold a beat for extra clocks. With sequential mode off, every beat uses the non-sequential wait count and one idle clock separates back-to-back bursts. With sequential mode on, the later beats use their own wait count and a request that is already waiting is chained onto the end of the current burst with no idle clock.

Top module: `sramBurstReader`

## Requirements
- R1: While reset is asserted and after reset until a request is taken, memCsN, memOeN and memWeN are high and busy, rdValid and done are low.
- R2: A request is taken at a rising edge where reqValid is high and busy is low. The burst has reqBeats beats, with values below 2 raised to 2 and values above 4 lowered to 4.
- R3: The first beat of a burst lasts cfgNsWait + 2 clocks with select low, so it always has at least one wait state.
- R4: Each later beat lasts w + 1 clocks, where w is cfgSqWait when cfgSeqEn is 1 and cfgNsWait when it is 0. At zero settings with sequential mode a 4-beat burst keeps select low for 5 clocks.
- R5: memRdy is sampled on the falling edge inside the final clock of a beat. When it is low, the beat gains one clock and memRdy is sampled again. memRdy during the wait clocks of a beat has no effect.
- R6: memAddr starts at reqAddr and grows after each beat by 1, 2 or 4 for reqSize codes 0, 1 and 2 (code 3 steps by 4). memHalf is high for code 1 and memWord is high for codes 2 and 3.
- R7: Read data is latched at the rising edge that ends a beat. rdValid is high for the following clock, and rdData then holds that beat's word.
- R8: done pulses for one clock together with the rdValid of the last beat.
- R9: With cfgSeqEn at 0 and reqValid held high, exactly one clock with memCsN high separates two bursts.
- R10: With cfgSeqEn at 1, a request held high is taken at the edge that ends the last beat, and memCsN stays low across the boundary.
- R11: After a burst, memAddr, memHalf and memWord keep their last values until the next request is taken.
- R12: memWeN stays high at all times, and memOeN equals memCsN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; control on rising edge, ready sampled on falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqAddr | input | AW | Start address |
| reqSize | input | 2 | Transfer size code: 0 byte, 1 halfword, 2/3 word |
| reqBeats | input | 3 | Beats in the burst, limited to 2..4 |
| cfgNsWait | input | 3 | Wait states for non-sequential beats |
| cfgSqWait | input | 3 | Wait states for later beats in sequential mode |
| cfgSeqEn | input | 1 | Sequential access mode enable |
| busy | output | 1 | New request cannot be taken this clock |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low, always high |
| memAddr | output | AW | Memory address |
| memHalf | output | 1 | Halfword transfer indicator |
| memWord | output | 1 | Word transfer indicator |
| memData | input | DW | Read data from memory |
| memRdy | input | 1 | External ready; low stretches the beat |
| rdValid | output | 1 | One-cycle pulse: rdData holds a new beat |
| rdData | output | DW | Captured read data |
| done | output | 1 | One-cycle pulse with the last beat's data |

## Verification
The hardest case to reach is the boundary between two bursts. The idle clock, or in sequential mode the seamless chaining, depends on a request already waiting when the last beat's ready sample comes in. The stimulus holds reqValid high from the first acceptance and retargets the address one clock later. It counts select-high clocks between the second and third data pulses and checks the first word of the second burst. Ready stalls are placed on exact clocks counted from acceptance, so that some fall inside wait clocks and must be ignored while others land on a beat's final clock and must add exactly one clock each.

// File: rtl/sbrPkg.sv
package sbrPkg;
  typedef struct packed {
    logic load;     // request taken this edge
    logic capture;  // a beat ends this edge
    logic advance;  // a non-final beat ends: step address
    logic last;     // final beat ends
  } sbrStrobeT;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [1:0] SIZE_HALF = 2'd1;
endpackage

// File: rtl/sbrCtrl.sv
module sbrCtrl
  import sbrPkg::*;
#(
  parameter int WAITW    = 3,
  parameter int BEATW    = 3,
  parameter int MINBEATS = 2,
  parameter int MAXBEATS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [BEATW-1:0] reqBeats,
  input  logic [WAITW-1:0] cfgNsWait,
  input  logic [WAITW-1:0] cfgSqWait,
  input  logic             cfgSeqEn,
  input  logic             memRdy,
  output logic             busy,
  output logic             accessOn,
  output sbrStrobeT        strobe
);
  localparam int BLW = (MAXBEATS > 2) ? $clog2(MAXBEATS) : 1;
  localparam int CW  = WAITW + 1;

  typedef enum logic {ST_IDLE, ST_ACCESS} stateT;

  stateT          state;
  logic [CW-1:0]  waitCnt;
  logic [BLW-1:0] beatLeft;
  logic           rdySampled;
  logic           beatEnd;
  logic           lastEnd;
  logic [BLW-1:0] firstLeft;

  // ready is looked at on the falling edge ahead of the transfer edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) rdySampled <= 1'b0;
    else       rdySampled <= memRdy;
  end

  always_comb begin
    int clamped;
    clamped = int'(reqBeats);
    if (clamped < MINBEATS) clamped = MINBEATS;
    if (clamped > MAXBEATS) clamped = MAXBEATS;
    firstLeft = BLW'(clamped - 1);
  end

  always_comb begin
    accessOn       = (state == ST_ACCESS);
    beatEnd        = accessOn && (waitCnt == '0) && rdySampled;
    lastEnd        = beatEnd && (beatLeft == '0);
    busy           = accessOn && !(lastEnd && cfgSeqEn);
    strobe.load    = reqValid && !busy;
    strobe.capture = beatEnd;
    strobe.advance = beatEnd && !lastEnd;
    strobe.last    = lastEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      beatLeft <= '0;
    end else if (strobe.load) begin
      state    <= ST_ACCESS;
      waitCnt  <= {1'b0, cfgNsWait} + CW'(1);
      beatLeft <= firstLeft;
    end else if (lastEnd) begin
      state    <= ST_IDLE;
    end else if (strobe.advance) begin
      beatLeft <= beatLeft - BLW'(1);
      waitCnt  <= cfgSeqEn ? {1'b0, cfgSqWait} : {1'b0, cfgNsWait};
    end else if (accessOn && waitCnt != '0) begin
      waitCnt  <= waitCnt - CW'(1);
    end
  end
endmodule

// File: rtl/sbrData.sv
module sbrData
  import sbrPkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  sbrStrobeT     strobe,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    reqSize,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic          memHalf,
  output logic          memWord,
  output logic [DW-1:0] rdData,
  output logic          rdValid,
  output logic          done
);
  logic [AW-1:0] addrQ;
  logic [1:0]    sizeQ;
  logic [AW-1:0] step;

  always_comb begin
    case (sizeQ)
      SIZE_BYTE: step = AW'(1);
      SIZE_HALF: step = AW'(2);
      default:   step = AW'(4);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      sizeQ <= '0;
    end else if (strobe.load) begin
      addrQ <= reqAddr;
      sizeQ <= reqSize;
    end else if (strobe.advance) begin
      addrQ <= addrQ + step;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      done    <= 1'b0;
    end else begin
      rdValid <= strobe.capture;
      done    <= strobe.last;
      if (strobe.capture) rdData <= memData;
    end
  end

  assign memAddr = addrQ;
  assign memHalf = (sizeQ == SIZE_HALF);
  assign memWord = sizeQ[1];
endmodule

// File: rtl/sramBurstReader.sv
module sramBurstReader
  import sbrPkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [AW-1:0] reqAddr,
  input  logic [1:0]    reqSize,
  input  logic [2:0]    reqBeats,
  input  logic [2:0]    cfgNsWait,
  input  logic [2:0]    cfgSqWait,
  input  logic          cfgSeqEn,
  output logic          busy,
  output logic          memCsN,
  output logic          memOeN,
  output logic          memWeN,
  output logic [AW-1:0] memAddr,
  output logic          memHalf,
  output logic          memWord,
  input  logic [DW-1:0] memData,
  input  logic          memRdy,
  output logic          rdValid,
  output logic [DW-1:0] rdData,
  output logic          done
);
  sbrStrobeT strobe;
  logic      accessOn;

  sbrCtrl #(.WAITW(3), .BEATW(3), .MINBEATS(2), .MAXBEATS(4)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBeats(reqBeats),
    .cfgNsWait(cfgNsWait), .cfgSqWait(cfgSqWait), .cfgSeqEn(cfgSeqEn),
    .memRdy(memRdy), .busy(busy), .accessOn(accessOn), .strobe(strobe)
  );

  sbrData #(.AW(AW), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqSize(reqSize), .memData(memData), .memAddr(memAddr),
    .memHalf(memHalf), .memWord(memWord), .rdData(rdData),
    .rdValid(rdValid), .done(done)
  );

  assign memCsN = !accessOn;
  assign memOeN = !accessOn;
  assign memWeN = 1'b1;
endmodule

// File: rtl/sbrChecker.sv
module sbrChecker #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          memCsN,
  input logic [AW-1:0] memAddr,
  input logic          memHalf,
  input logic          memWord,
  input logic          rdValid,
  input logic          done
);
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN) && !rdValid) |-> $stable(memAddr)); // R6
  AST_SIZE_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN) && !rdValid) |-> $stable({memHalf, memWord})); // R11
  AST_VALID_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!memCsN)); // R7
  AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    done |-> rdValid); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
endmodule

bind sramBurstReader sbrChecker #(.AW(AW)) uChk (
  .clk(clk), .rstN(rstN), .memCsN(memCsN), .memAddr(memAddr),
  .memHalf(memHalf), .memWord(memWord), .rdValid(rdValid), .done(done)
);

// File: tb/tb_sramBurstReader.sv
`timescale 1ns/1ps
module tb_sramBurstReader;
  localparam int AW = 24;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [1:0]    reqSize = '0;
  logic [2:0]    reqBeats = 3'd2;
  logic [2:0]    cfgNsWait = '0;
  logic [2:0]    cfgSqWait = '0;
  logic          cfgSeqEn = 1'b0;
  logic          busy, memCsN, memOeN, memWeN, memHalf, memWord;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;
  logic          memRdy = 1'b1;
  logic          rdValid, done;
  logic [DW-1:0] rdData;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] memVal(logic [AW-1:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0]};
  endfunction

  assign memData = (!memCsN && !memOeN) ? memVal(memAddr) : '0;

  sramBurstReader #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqBeats(reqBeats), .cfgNsWait(cfgNsWait),
    .cfgSqWait(cfgSqWait), .cfgSeqEn(cfgSeqEn), .busy(busy),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr),
    .memHalf(memHalf), .memWord(memWord), .memData(memData),
    .memRdy(memRdy), .rdValid(rdValid), .rdData(rdData), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic resetTest();
    rstN = 1'b0;
    #13;
    chk(memCsN && memOeN && memWeN, "R1", "strobes in reset", {memCsN, memOeN, memWeN}, 3'b111);
    chk(!busy && !rdValid && !done, "R1", "flags in reset", {busy, rdValid, done}, 0);
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    #7;
    chk(memCsN && memOeN && memWeN && !busy && !rdValid && !done, "R1", "idle after reset",
        {memCsN, memOeN, memWeN, busy, rdValid, done}, 6'b111000);
  endtask

  // one burst; stall cycles are counted from 1 = first clock after acceptance
  task automatic singleBurst(input string req, input logic [AW-1:0] addr, input logic [1:0] size,
                             input int beats, input int ns, input int sq, input bit seq,
                             input int stallFrom, input int stallLen, input int extra);
    int eb, stepV, w, csLow, nv, cyc;
    bit acc, strobeOk;
    eb = (beats < 2) ? 2 : (beats > 4 ? 4 : beats);
    stepV = (size == 2'd0) ? 1 : (size == 2'd1 ? 2 : 4);
    w = seq ? sq : ns;
    @(posedge clk); #1;
    cfgNsWait = 3'(ns); cfgSqWait = 3'(sq); cfgSeqEn = seq;
    reqAddr = addr; reqSize = size; reqBeats = 3'(beats); reqValid = 1'b1; memRdy = 1'b1;
    acc = 1'b0;
    for (int g = 0; g < 20 && !acc; g++) begin
      #6; acc = !busy;
      @(posedge clk); #1;
    end
    reqValid = 1'b0;
    csLow = 0; nv = 0; cyc = 1; strobeOk = 1'b1;
    for (int g = 0; g < 300; g++) begin
      memRdy = !(cyc >= stallFrom && cyc < stallFrom + stallLen);
      #6;
      if (!memCsN) csLow++;
      if (memOeN !== memCsN || memWeN !== 1'b1) strobeOk = 1'b0;
      if (rdValid) begin
        chk(rdData == memVal(addr + AW'(nv * stepV)), "R7", "beat data (R6 address)",
            rdData, memVal(addr + AW'(nv * stepV)));
        nv++;
      end
      if (done) begin
        chk(rdValid && nv == eb, "R8", "done with last beat", nv, eb);
        break;
      end
      @(posedge clk); #1; cyc++;
    end
    memRdy = 1'b1;
    chk(nv == eb, "R2", {req, " beat count"}, nv, eb);
    chk(csLow == (ns + 2) + (eb - 1) * (w + 1) + extra, req, "select-low clocks",
        csLow, (ns + 2) + (eb - 1) * (w + 1) + extra);
    chk(strobeOk, "R12", "WE high and OE equals CS", strobeOk, 1);
  endtask

  task automatic holdCheck(input logic [AW-1:0] expAddr, input bit expHalf, input bit expWord);
    repeat (3) @(posedge clk);
    #7;
    chk(memAddr == expAddr && memHalf == expHalf && memWord == expWord && memCsN,
        "R11", "address and size hold after burst",
        {memAddr, memHalf, memWord}, {expAddr, expHalf, expWord});
  endtask

  task automatic backToBack(input bit seq, input int expGap);
    int acc, nv, dones, gap;
    bit seenLow;
    @(posedge clk); #1;
    cfgNsWait = 3'd0; cfgSqWait = 3'd0; cfgSeqEn = seq;
    reqAddr = 24'h000100; reqSize = 2'd2; reqBeats = 3'd2; reqValid = 1'b1; memRdy = 1'b1;
    acc = 0; nv = 0; dones = 0; gap = 0; seenLow = 1'b0;
    for (int g = 0; g < 100; g++) begin
      bit takeNow;
      #6;
      takeNow = reqValid && !busy;
      if (!memCsN) seenLow = 1'b1;
      if (memCsN && seenLow && nv < 2) gap++;
      if (rdValid) begin
        if (nv == 2) chk(rdData == memVal(24'h000200), seq ? "R10" : "R9",
                         "second burst first word", rdData, memVal(24'h000200));
        nv++;
      end
      if (done) dones++;
      if (dones == 2) break;
      @(posedge clk); #1;
      if (takeNow) begin
        acc++;
        if (acc == 1) reqAddr = 24'h000200;
        else reqValid = 1'b0;
      end
    end
    reqValid = 1'b0;
    chk(nv == 4 && dones == 2, seq ? "R10" : "R9", "two bursts complete", nv, 4);
    chk(gap == expGap, seq ? "R10" : "R9", "select-high clocks between bursts", gap, expGap);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    resetTest();
    // R3 R4: minimum pattern 1-0-0-0 with sequential mode
    singleBurst("R4", 24'h001000, 2'd2, 4, 0, 0, 1'b1, 0, 0, 0);
    holdCheck(24'h00100C, 1'b0, 1'b1);
    // R3: byte, non-sequential wait 1 used on every beat
    singleBurst("R3", 24'h000201, 2'd0, 3, 1, 5, 1'b0, 0, 0, 0);
    holdCheck(24'h000203, 1'b0, 1'b0);
    // R6: halfword steps, sequential wait 2
    singleBurst("R6", 24'h003002, 2'd1, 4, 0, 2, 1'b1, 0, 0, 0);
    holdCheck(24'h003008, 1'b1, 1'b0);
    // R6: size code 3 acts as word
    singleBurst("R6", 24'h000400, 2'd3, 2, 0, 0, 1'b0, 0, 0, 0);
    holdCheck(24'h000404, 1'b0, 1'b1);
    // R2: clamping of the beat count
    singleBurst("R2", 24'h000500, 2'd2, 1, 0, 0, 1'b0, 0, 0, 0);
    singleBurst("R2", 24'h000600, 2'd2, 7, 0, 0, 1'b1, 0, 0, 0);
    // R5: stall on first beat's final clock (cycles 2..4) adds 3
    singleBurst("R5", 24'h000700, 2'd2, 2, 0, 0, 1'b1, 2, 3, 3);
    // R5: stall on second beat's final clock (cycle 3) adds 1
    singleBurst("R5", 24'h000800, 2'd2, 2, 0, 0, 1'b1, 3, 1, 1);
    // R5: ready low only during wait clocks 1..4 of a 5-clock first beat has no effect
    singleBurst("R5", 24'h000900, 2'd2, 2, 3, 0, 1'b0, 1, 4, 0);
    backToBack(1'b0, 1);
    backToBack(1'b1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule